// File: doc/BRIEF.md
# Interval Timer Rate-Generator Channel

One channel of an interval timer that divides a count-enable stream by a 16-bit divisor and emits a periodic interrupt pulse. Software reaches it through a byte-wide write port with two addresses: a control address that selects the operating format, and a data address through which the divisor arrives as two bytes, low first. Only the rate-generator format with binary counting and low-then-high byte loading is built. Any other control byte is accepted but leaves the channel idle.

The count clock is a synchronous enable (`cnt_tick`) on the system clock, so the division ratio seen at the interrupt is in ticks and not in system cycles. With a tick rate near 1.19 MHz, a divisor of 1193 gives roughly one interrupt per millisecond. Once running, the channel reloads itself at the end of every period. A divisor written while running takes effect at the next reload.

Top module: `ivt_channel`

## Requirements
- R1: A control write (`wr_sel_ctl`=1) is supported only if its fields are as follows: bits [7:6]=00 (this channel), bits [5:4]=11 (low then high byte), bits [3:1]=010 (rate generator) and bit 0=0 (binary). The value 0x34 is such a byte. Any other control byte leaves the channel idle, with `irq_pulse` low and `out_level` high.
- R2: After a supported control write, the first data write (`wr_sel_ctl`=0) is the divisor's low byte and the second is its high byte.
- R3: Counting starts only once the high byte has been written. Before that, no interrupt is produced.
- R4: With divisor N, the first interrupt follows the (N-1)th tick after loading. Later interrupts repeat every N ticks.
- R5: `out_level` falls on the tick that brings the count to 1 and rises again on the next tick. At all other times while running it is high.
- R6: `irq_pulse` is high for exactly one system cycle, in the cycle in which `out_level` has just fallen.
- R7: A divisor of 0 counts as 65536.
- R8: A control write stops counting, drives `out_level` high and returns the byte sequence to the low byte.
- R9: A divisor pair written while the channel runs does not alter the current period. It is used from the next reload on.
- R10: Without `cnt_tick` the count holds.
- R11: After reset the channel is idle with `out_level` high and `irq_pulse` low. Data writes made while idle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| wr_sel_ctl | input | 1 | 1 selects the control address, 0 the data address |
| wr_byte | input | 8 | Write data |
| cnt_tick | input | 1 | Count enable, one system cycle per count step |
| irq_pulse | output | 1 | One-cycle interrupt at each period end |
| out_level | output | 1 | Rate-generator output waveform |

## Verification
The divisor table covers the smallest legal divisors 2 and 3, a near-millisecond value, a value of 256 with a zero low byte, and prime values. Tick ratios of 1, 2, 3 and 4 are used, so that a design counting system cycles instead of ticks, or reloading one count early or late, gives a different gap. Directed cases separate a lone low byte from a full pair, a swapped byte order (0x02 then 0x01 gives 258, not 513), and a mid-run divisor change (first gap old, second gap new). They also cover a set of unsupported control bytes differing from 0x34 in one field each, and the zero divisor, whose first interrupt lands after 65535 ticks.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

    localparam int BYTE_W     = 8;
    localparam int DEF_CNT_W  = 16;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT_LO,
        ST_WAIT_HI,
        ST_RUN
    } seq_state_e;

    typedef struct packed {
        logic [1:0] chan;
        logic [1:0] access;
        logic [2:0] mode;
        logic       bcd;
    } ctl_word_t;

    localparam logic [1:0] CHAN_THIS  = 2'b00;
    localparam logic [1:0] ACC_LO_HI  = 2'b11;
    localparam logic [2:0] MODE_RATE  = 3'b010;

    function automatic logic ctl_supported(ctl_word_t w);
        return (w.chan == CHAN_THIS) && (w.access == ACC_LO_HI) &&
               (w.mode == MODE_RATE) && !w.bcd;
    endfunction

endpackage

// File: rtl/ivt_seq.sv
module ivt_seq
    import ivt_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic                 wr_sel_ctl,
    input  logic [BYTE_W-1:0]    wr_byte,
    output logic                 run,
    output logic                 start,
    output logic [CNT_W-1:0]     start_div,
    output logic [CNT_W-1:0]     reload_div
);

    localparam int HI_W = CNT_W - BYTE_W;

    seq_state_e          st;
    logic [BYTE_W-1:0]   lo_q;
    logic                ptr_hi;
    logic [CNT_W-1:0]    div_q;
    logic                ctl_wr;
    logic                dat_wr;
    ctl_word_t           cw;

    assign cw         = ctl_word_t'(wr_byte);
    assign ctl_wr     = wr_en && wr_sel_ctl;
    assign dat_wr     = wr_en && !wr_sel_ctl;
    assign run        = (st == ST_RUN);
    assign start      = dat_wr && (st == ST_WAIT_HI);
    assign start_div  = {wr_byte[HI_W-1:0], lo_q};
    assign reload_div = div_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            lo_q   <= '0;
            ptr_hi <= 1'b0;
            div_q  <= '0;
        end else if (ctl_wr) begin
            st     <= ctl_supported(cw) ? ST_WAIT_LO : ST_IDLE;
            ptr_hi <= 1'b0;
        end else if (dat_wr) begin
            case (st)
                ST_WAIT_LO: begin
                    lo_q <= wr_byte;
                    st   <= ST_WAIT_HI;
                end
                ST_WAIT_HI: begin
                    div_q <= {wr_byte[HI_W-1:0], lo_q};
                    st    <= ST_RUN;
                end
                ST_RUN: begin
                    if (!ptr_hi) begin
                        lo_q   <= wr_byte;
                        ptr_hi <= 1'b1;
                    end else begin
                        div_q  <= {wr_byte[HI_W-1:0], lo_q};
                        ptr_hi <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    p_ctl_stops_r8: assert property (@(posedge clk) disable iff (rst)
        ctl_wr |=> !run);

    p_run_needs_hi_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(run) |-> $past(dat_wr));

endmodule

// File: rtl/ivt_rate_cnt.sv
module ivt_rate_cnt
    import ivt_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              start,
    input  logic [CNT_W-1:0]  start_div,
    input  logic [CNT_W-1:0]  reload_div,
    input  logic              tick,
    output logic              out_lvl,
    output logic              irq
);

    localparam int CW = CNT_W + 1;
    localparam logic [CW-1:0] ONE = CW'(1);

    function automatic logic [CW-1:0] eff_div(logic [CNT_W-1:0] d);
        logic [CW-1:0] r;
        r = {1'b0, d};
        if (d == '0) r[CNT_W] = 1'b1;
        return r;
    endfunction

    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_nx;

    always_comb begin
        if (cnt == ONE) cnt_nx = eff_div(reload_div);
        else            cnt_nx = cnt - ONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            out_lvl <= 1'b1;
            irq     <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (start) begin
                cnt     <= eff_div(start_div);
                out_lvl <= 1'b1;
            end else if (!run) begin
                out_lvl <= 1'b1;
            end else if (tick) begin
                cnt     <= cnt_nx;
                out_lvl <= (cnt_nx != ONE);
                irq     <= (cnt_nx == ONE);
            end
        end
    end

    p_irq_one_cycle_r6: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    p_irq_out_low_r6: assert property (@(posedge clk) disable iff (rst)
        irq |-> !out_lvl);

    p_hold_no_tick_r10: assert property (@(posedge clk) disable iff (rst)
        (!tick && !start) |=> $stable(cnt));

    p_cnt_nonzero_r7: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt != '0));

endmodule

// File: rtl/ivt_channel.sv
module ivt_channel
    import ivt_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_sel_ctl,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              cnt_tick,
    output logic              irq_pulse,
    output logic              out_level
);

    logic             run;
    logic             start;
    logic [CNT_W-1:0] start_div;
    logic [CNT_W-1:0] reload_div;

    ivt_seq #(.CNT_W(CNT_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_sel_ctl (wr_sel_ctl),
        .wr_byte    (wr_byte),
        .run        (run),
        .start      (start),
        .start_div  (start_div),
        .reload_div (reload_div)
    );

    ivt_rate_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .start      (start),
        .start_div  (start_div),
        .reload_div (reload_div),
        .tick       (cnt_tick),
        .out_lvl    (out_level),
        .irq        (irq_pulse)
    );

    p_idle_no_irq_r3: assert property (@(posedge clk) disable iff (rst)
        !run |=> !irq_pulse);

    p_idle_out_high_r1: assert property (@(posedge clk) disable iff (rst)
        (!run && !$past(run)) |-> out_level);

endmodule

// File: tb/test_ivt_channel.sv
module test_ivt_channel;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    typedef struct packed {
        logic [15:0] div;
        logic [7:0]  ratio;
        logic [31:0] first;
        logic [31:0] gap;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [0:NVEC-1] = '{
        '{16'd3,    8'd1, 32'd2,    32'd3},
        '{16'd2,    8'd1, 32'd1,    32'd2},
        '{16'd5,    8'd3, 32'd4,    32'd5},
        '{16'd1193, 8'd1, 32'd1192, 32'd1193},
        '{16'd256,  8'd2, 32'd255,  32'd256},
        '{16'd7,    8'd4, 32'd6,    32'd7}
    };

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic       wr_sel_ctl;
    logic [7:0] wr_byte;
    logic       cnt_tick;
    logic       irq_pulse;
    logic       out_level;

    int n_chk  = 0;
    int n_fail = 0;
    int pt [0:3];
    int p_seen, bad_w, bad_o, lows;
    bit done = 1'b0;

    ivt_channel i_ivt_channel (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel_ctl(wr_sel_ctl),
        .wr_byte(wr_byte), .cnt_tick(cnt_tick),
        .irq_pulse(irq_pulse), .out_level(out_level)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input bit ctl, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel_ctl = ctl; wr_byte = d; cnt_tick = 1'b0;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load(input logic [15:0] d);
        wr(1'b1, 8'h34);
        wr(1'b0, d[7:0]);
        wr(1'b0, d[15:8]);
    endtask

    // Issue ticks every 'ratio' cycles until npulses interrupts or limit ticks.
    task automatic measure(input int ratio, input int npulses, input int limit);
        int tk, cyc;
        bit prev;
        tk = 0; cyc = 0; prev = 1'b0;
        p_seen = 0; bad_w = 0; bad_o = 0; lows = 0;
        forever begin
            @(negedge clk);
            if (!out_level) lows++;
            if (irq_pulse) begin
                if (prev) bad_w++;
                if (out_level) bad_o++;
                if (p_seen < 4) pt[p_seen] = tk;
                p_seen++;
            end
            prev = irq_pulse;
            if (p_seen >= npulses || tk >= limit) begin
                cnt_tick = 1'b0;
                break;
            end
            if ((cyc % ratio) == ratio - 1) begin
                cnt_tick = 1'b1; tk++;
            end else begin
                cnt_tick = 1'b0;
            end
            cyc++;
        end
    endtask

    task automatic quiet(input int n);
        p_seen = 0; lows = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (irq_pulse) p_seen++;
            if (!out_level) lows++;
            cnt_tick = 1'b1;
        end
        @(negedge clk);
        if (irq_pulse) p_seen++;
        if (!out_level) lows++;
        cnt_tick = 1'b0;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_sel_ctl = 1'b0; wr_byte = '0; cnt_tick = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11 reset state
        check(irq_pulse == 1'b0, "R11 irq after reset", irq_pulse, 0);
        check(out_level == 1'b1, "R11 out after reset", out_level, 1);

        // R11 data writes while idle are ignored
        wr(1'b0, 8'h03); wr(1'b0, 8'h00);
        quiet(40);
        check(p_seen == 0, "R11 idle data writes", p_seen, 0);

        // Vector table: R1 R2 R4 R5 R6 R10
        for (int v = 0; v < NVEC; v++) begin
            load(VECS[v].div);
            measure(int'(VECS[v].ratio), 3, 100000);
            check(p_seen == 3, "R4 pulse count", p_seen, 3);
            check(pt[0] == int'(VECS[v].first), "R4 first interval", pt[0], int'(VECS[v].first));
            check(pt[1] - pt[0] == int'(VECS[v].gap), "R4 R10 period", pt[1] - pt[0], int'(VECS[v].gap));
            check(pt[2] - pt[1] == int'(VECS[v].gap), "R4 reload period", pt[2] - pt[1], int'(VECS[v].gap));
            check(bad_w == 0, "R6 pulse width", bad_w, 0);
            check(bad_o == 0, "R6 out low with irq", bad_o, 0);
            check(lows == 2 * int'(VECS[v].ratio) + 1, "R5 low phase length", lows,
                  2 * int'(VECS[v].ratio) + 1);
        end

        // R3 low byte alone does not start counting
        wr(1'b1, 8'h34);
        wr(1'b0, 8'h03);
        quiet(40);
        check(p_seen == 0, "R3 no count before high byte", p_seen, 0);
        wr(1'b0, 8'h00);
        measure(1, 1, 100);
        check(pt[0] == 2, "R3 start after high byte", pt[0], 2);

        // R2 byte order: 0x02 then 0x01 -> 258
        load(16'h0102);
        measure(1, 1, 1000);
        check(pt[0] == 257, "R2 low byte first", pt[0], 257);

        // R1 R8 unsupported control bytes stop and idle the channel
        begin
            logic [7:0] bad_codes [0:4];
            bad_codes = '{8'h36, 8'h35, 8'h74, 8'h30, 8'h14};
            for (int k = 0; k < 5; k++) begin
                load(16'd3);
                measure(1, 1, 20);
                wr(1'b1, bad_codes[k]);
                quiet(20);
                check(p_seen == 0, "R1 unsupported control no irq", p_seen, 0);
                check(lows == 0, "R8 out high after control", lows, 0);
            end
            wr(1'b0, 8'h03); wr(1'b0, 8'h00);
            quiet(20);
            check(p_seen == 0, "R1 data ignored after unsupported", p_seen, 0);
        end

        // R8 control write mid-run resets byte pointer
        load(16'd9);
        measure(1, 1, 50);
        wr(1'b0, 8'h06);
        wr(1'b1, 8'h34);
        wr(1'b0, 8'h04);
        wr(1'b0, 8'h00);
        measure(1, 1, 50);
        check(pt[0] == 3, "R8 restart with new divisor", pt[0], 3);

        // R9 divisor written during run takes effect at next reload
        load(16'd10);
        wr(1'b0, 8'h04); wr(1'b0, 8'h00);
        measure(1, 2, 100);
        check(pt[0] == 9, "R9 current period kept", pt[0], 9);
        check(pt[1] - pt[0] == 4, "R9 new period after reload", pt[1] - pt[0], 4);

        // R7 zero divisor means 65536
        load(16'h0000);
        measure(1, 1, 70000);
        check(pt[0] == 65535, "R7 zero divisor first interval", pt[0], 65535);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule